// File: doc/BRIEF.md
# DMA Channel Chain Trigger Generator

This block follows the transfer requests (TRs) that one active DMA channel issues and turns them into synchronization events for a second, chained channel. When the source channel starts, the block captures the channel's B and C counts, its sync mode, the 5-bit target channel code and two chaining enables: one for the final TR and one for the intermediate TRs. It also captures a timing select that says whether a TR counts when it is submitted (early completion) or when it completes (normal completion).

From those counts the block works out how many TRs the channel will issue. A-synchronized transfers issue one TR per B-count row of every C-count frame. AB-synchronized transfers issue one TR per frame. On each counted TR pulse the block decides whether this TR is the last one. If the enable for that kind of TR is set, it raises one bit of a 32-bit event vector, the bit that matches the target channel. The block only signals the target channel. It never changes any transfer parameters, and it does not move data.

Top module: `chain_trigger_gen`

## Requirements
- R1: After reset, `chain_evt` is all zeros. Until a `start` arrives, TR pulses produce no event.
- R2: With `sync_ab`=0 (A-synchronized), the channel has `bcnt`×`ccnt` TRs.
- R3: With `sync_ab`=1 (AB-synchronized), the channel has `ccnt` TRs, and `bcnt` has no effect.
- R4: With only `final_en` set, exactly one event fires, on the last TR.
- R5: With only `inter_en` set, an event fires on every TR except the last.
- R6: With both enables set, an event fires on every TR.
- R7: With both enables clear, no event fires.
- R8: With `early_sel`=1, only `tr_submit` pulses count. With `early_sel`=0, only `tr_done` pulses count. A pulse of the other kind has no effect.
- R9: An event is a one-cycle pulse on bit `tgt_code` of `chain_evt`, with all other bits zero. It appears in the cycle after the counted TR pulse.
- R10: Counted pulses that arrive after the last TR produce no event until the next `start`. A zero count means the channel has no TRs.
- R11: `start` reloads the count. A TR pulse in the same cycle as `start` is not counted, and `chain_evt` is zero in the cycle after `start`.
- R12: The configuration inputs are sampled only on `start`. Changing them later has no effect on the running channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Channel start; captures the configuration and loads the TR count |
| bcnt | input | 16 | B count (rows per frame) |
| ccnt | input | 16 | C count (frames) |
| sync_ab | input | 1 | 1 = AB-synchronized, 0 = A-synchronized |
| tgt_code | input | 5 | Target channel number, 0 to 31 |
| final_en | input | 1 | Chain on the final TR |
| inter_en | input | 1 | Chain on intermediate TRs |
| early_sel | input | 1 | 1 = count TR submissions, 0 = count TR completions |
| tr_submit | input | 1 | TR submitted pulse |
| tr_done | input | 1 | TR completed pulse |
| chain_evt | output | 32 | One-hot chain event toward the target channel |

## Verification
The bench sweeps every combination of sync mode, the two enables and the timing select, for B and C counts from 0 to 3. It varies the target code across the runs and changes the configuration inputs right after each start. Every counted pulse, plus two pulses past the end, is checked against an event computed from the TR count in the bench. This tells apart a wrong TR count, a wrong last-TR decision, swapped enables and a wrong target bit. Each counted pulse is followed by a pulse of the other kind, and that pulse must stay silent, which separates submission timing from completion timing. A directed case raises a TR pulse in the same cycle as start to pin down which of the two takes priority.

// File: rtl/chain_pkg.sv
package chain_pkg;
    parameter int CH_CNT_W  = 16;
    parameter int CH_NUM    = 32;
    parameter int CH_CODE_W = $clog2(CH_NUM);
    parameter int CH_TOT_W  = 2 * CH_CNT_W;

    typedef struct packed {
        logic [CH_TOT_W-1:0]  remain;
        logic [CH_CODE_W-1:0] tgt;
        logic                 fin_en;
        logic                 int_en;
        logic                 early;
        logic [CH_NUM-1:0]    evt;
    } chain_state_t;
endpackage

// File: rtl/chain_tr_counter.sv
module chain_tr_counter #(
    parameter int CNT_W = chain_pkg::CH_CNT_W,
    localparam int TOT_W = 2 * CNT_W
) (
    input  logic             load,
    input  logic             sync_ab,
    input  logic [CNT_W-1:0] bcnt,
    input  logic [CNT_W-1:0] ccnt,
    input  logic             tick,
    input  logic [TOT_W-1:0] remain_q,
    output logic [TOT_W-1:0] remain_d,
    output logic             hit,
    output logic             is_last
);
    logic [TOT_W-1:0] b_ext;
    logic [TOT_W-1:0] c_ext;
    logic [TOT_W-1:0] total;

    always_comb begin
        b_ext    = {{CNT_W{1'b0}}, bcnt};
        c_ext    = {{CNT_W{1'b0}}, ccnt};
        total    = sync_ab ? c_ext : TOT_W'(b_ext * c_ext);
        hit      = !load && tick && (remain_q != '0);
        is_last  = (remain_q == TOT_W'(1));
        remain_d = remain_q;
        if (load) begin
            remain_d = total;
        end else if (hit) begin
            remain_d = remain_q - TOT_W'(1);
        end
    end
endmodule

// File: rtl/chain_onehot.sv
module chain_onehot #(
    parameter int NUM   = chain_pkg::CH_NUM,
    localparam int CW   = $clog2(NUM)
) (
    input  logic          fire,
    input  logic [CW-1:0] code,
    output logic [NUM-1:0] vec
);
    for (genvar i = 0; i < NUM; i++) begin : g_bit
        assign vec[i] = fire && (code == CW'(i));
    end
endmodule

// File: rtl/chain_trigger_gen.sv
module chain_trigger_gen
    import chain_pkg::*;
#(
    parameter int CNT_W = CH_CNT_W,
    parameter int NUM   = CH_NUM,
    localparam int CW   = $clog2(NUM),
    localparam int TOT_W = 2 * CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] bcnt,
    input  logic [CNT_W-1:0] ccnt,
    input  logic             sync_ab,
    input  logic [CW-1:0]    tgt_code,
    input  logic             final_en,
    input  logic             inter_en,
    input  logic             early_sel,
    input  logic             tr_submit,
    input  logic             tr_done,
    output logic [NUM-1:0]   chain_evt
);
    chain_state_t s_q, s_d;

    logic             tick;
    logic             hit;
    logic             is_last;
    logic             fire;
    logic [TOT_W-1:0] remain_d;
    logic [NUM-1:0]   evt_vec;

    assign tick = s_q.early ? tr_submit : tr_done;

    chain_tr_counter #(.CNT_W(CNT_W)) u_cnt (
        .load     (start),
        .sync_ab  (sync_ab),
        .bcnt     (bcnt),
        .ccnt     (ccnt),
        .tick     (tick),
        .remain_q (s_q.remain),
        .remain_d (remain_d),
        .hit      (hit),
        .is_last  (is_last)
    );

    assign fire = hit && (is_last ? s_q.fin_en : s_q.int_en);

    chain_onehot #(.NUM(NUM)) u_dec (
        .fire (fire),
        .code (s_q.tgt),
        .vec  (evt_vec)
    );

    always_comb begin
        s_d        = s_q;
        s_d.remain = remain_d;
        s_d.evt    = evt_vec;
        if (start) begin
            s_d.tgt    = tgt_code;
            s_d.fin_en = final_en;
            s_d.int_en = inter_en;
            s_d.early  = early_sel;
            s_d.evt    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign chain_evt = s_q.evt;
endmodule

// File: rtl/chain_trigger_chk.sv
module chain_trigger_chk #(
    parameter int NUM = chain_pkg::CH_NUM,
    localparam int CW = $clog2(NUM)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           tr_submit,
    input logic           tr_done,
    input logic           early_q,
    input logic           fin_q,
    input logic           int_q,
    input logic [CW-1:0]  tgt_q,
    input logic [NUM-1:0] chain_evt
);
    // R9
    evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chain_evt));

    // R9
    evt_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_evt != '0) |-> chain_evt[tgt_q]);

    // R11
    start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (chain_evt == '0));

    // R7
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !fin_q && !int_q) |=> (chain_evt == '0));

    // R8
    evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_evt != '0) |-> (early_q ? $past(tr_submit) : $past(tr_done)));
endmodule

bind chain_trigger_gen chain_trigger_chk #(.NUM(NUM)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tr_submit (tr_submit),
    .tr_done   (tr_done),
    .early_q   (s_q.early),
    .fin_q     (s_q.fin_en),
    .int_q     (s_q.int_en),
    .tgt_q     (s_q.tgt),
    .chain_evt (chain_evt)
);

// File: tb/tb_chain_trigger_gen.sv
module tb_chain_trigger_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] bcnt = '0;
    logic [15:0] ccnt = '0;
    logic        sync_ab = 1'b0;
    logic [4:0]  tgt_code = '0;
    logic        final_en = 1'b0;
    logic        inter_en = 1'b0;
    logic        early_sel = 1'b0;
    logic        tr_submit = 1'b0;
    logic        tr_done = 1'b0;
    logic [31:0] chain_evt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    chain_trigger_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bcnt(bcnt), .ccnt(ccnt),
        .sync_ab(sync_ab), .tgt_code(tgt_code), .final_en(final_en),
        .inter_en(inter_en), .early_sel(early_sel), .tr_submit(tr_submit),
        .tr_done(tr_done), .chain_evt(chain_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: chain_evt=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle pulse of submit (kind=1) or done (kind=0), then sample result
    task automatic pulse(input bit kind, input string req, input logic [31:0] exp);
        @(negedge clk);
        tr_submit = kind;
        tr_done   = !kind;
        @(negedge clk);
        tr_submit = 1'b0;
        tr_done   = 1'b0;
        check(req, chain_evt, exp);
    endtask

    task automatic do_start(input bit sab, input bit fe, input bit ie, input bit er,
                            input int b, input int c, input int tg);
        @(negedge clk);
        start = 1'b1; sync_ab = sab; final_en = fe; inter_en = ie; early_sel = er;
        bcnt = 16'(b); ccnt = 16'(c); tgt_code = 5'(tg);
        @(negedge clk);
        start = 1'b0;
        // R12: scramble configuration after capture
        sync_ab = !sab; final_en = !fe; inter_en = !ie; early_sel = !er;
        bcnt = 16'd7; ccnt = 16'd7; tgt_code = 5'(tg) ^ 5'd5;
        check("R11 quiet after start", chain_evt, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", chain_evt, 32'h0);
        rst_n = 1'b1;
        // R1: no start yet, pulses ignored
        pulse(1'b0, "R1 done before start", 32'h0);
        pulse(1'b1, "R1 submit before start", 32'h0);

        for (int sab = 0; sab < 2; sab++)
        for (int en = 0; en < 4; en++)
        for (int er = 0; er < 2; er++)
        for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
            int ntr;
            int tg;
            bit fe;
            bit ie;
            fe  = en[1];
            ie  = en[0];
            tg  = (sab * 7 + en * 5 + er * 3 + b * 11 + c) % 32;
            // R2 / R3: expected TR count
            ntr = (sab != 0) ? c : b * c;
            do_start(sab[0], fe, ie, er[0], b, c, tg);
            for (int k = 1; k <= ntr + 2; k++) begin
                bit f;
                string rq;
                if (k > ntr) begin
                    f = 1'b0; rq = "R10 past last";
                end else if (k == ntr) begin
                    f = fe; rq = (sab != 0) ? "R3/R4/R6 last TR" : "R2/R4/R6 last TR";
                end else begin
                    f = ie; rq = (sab != 0) ? "R3/R5/R6 mid TR" : "R2/R5/R6 mid TR";
                end
                if (!fe && !ie) rq = "R7 no enables";
                pulse(er[0], rq, f ? (32'd1 << tg) : 32'h0);
                // R8: other-kind pulse ignored; also shows R9 single-cycle width
                pulse(!er[0], "R8 other kind ignored", 32'h0);
            end
        end

        // R11: pulse in the same cycle as start is not counted
        @(negedge clk);
        start = 1'b1; sync_ab = 1'b0; bcnt = 16'd2; ccnt = 16'd1; tgt_code = 5'd31;
        final_en = 1'b1; inter_en = 1'b1; early_sel = 1'b0; tr_done = 1'b1;
        @(negedge clk);
        start = 1'b0; tr_done = 1'b0;
        check("R11 start beats pulse", chain_evt, 32'h0);
        pulse(1'b0, "R11 first TR", 32'h8000_0000);
        pulse(1'b0, "R11 second TR", 32'h8000_0000);
        pulse(1'b0, "R11 third ignored", 32'h0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule